// File: doc/BRIEF.md
# Interrupt Status Register Unit

This unit keeps the read-side status state of a small bus-interface controller and drives its single interrupt line. The state covers the status byte, the interrupt-reason byte, the sequence-step counter, the FIFO-flags byte, a configuration byte and a bank of upper registers. A host accesses it through a byte-wide port with a 4-bit address, a write strobe, a read strobe and a combinational readback bus. The command and transfer logic do not write these registers through the host port. They post events through dedicated request inputs, and the unit turns each event into register updates and an interrupt.

The unit also applies the side effects of host accesses. Reading the interrupt-reason byte is destructive: the read returns the old value, and the clock edge that ends the read clears the reason and the terminal-count flag, drops the interrupt and parks the sequence step at 4. Writing either low transfer-count location clears the terminal-count flag. A synchronous active-low hardware reset and a software reset pulse both return every register to its initial value.

Top module: `isr_unit`

## Requirements
- R1: After reset, the status (addr 4), reason (addr 5), step (addr 6) and flags (addr 7) registers read 0. The configuration byte (addr 8) reads 0x07, address 0xE reads the chip code 0x04, every other address reads 0, and `irq` is low.
- R2: An event request (`evt_valid` high for one cycle) loads status bits 6:0 from `evt_status`, the reason from `evt_reason` and the step from `evt_step`, and sets status bit 7 (interrupt pending). `irq` is high from the next cycle. A further event while `irq` is already high keeps it high.
- R3: A host read of address 5 returns the reason value held before the read. From the next cycle the reason reads 0, status bits 7 and 4 read 0, the other status bits are unchanged, the step reads 4 and `irq` is low.
- R4: Status bits 2:0 carry the bus-phase code exactly as posted: 0 data out, 1 data in, 2 command, 3 status, 6 message out, 7 message in.
- R5: Host writes to addresses 4, 5, 6, 7, 9 and 10 do not change any readback value.
- R6: A host write to address 8 or to any address from 0xB to 0xF is returned by a read of the same address from the next cycle.
- R7: A `sw_rst` pulse drops `irq` at the next cycle and restores every value listed in R1.
- R8: A host write to address 0 or 1 clears status bit 4 (terminal count) and leaves the other status bits and `irq` unchanged.
- R9: A host read of any address other than 2 or 5 changes no register and does not change `irq`.
- R10: When an event request and a read of address 5 occur in the same cycle, the event is applied in full and the clear is dropped: `irq` stays high, and the reason, step and status hold the posted values.
- R11: A flags request (`flags_valid`) loads `flags_val` into the flags register at address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst | input | 1 | Software reset pulse from command logic |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Combinational readback of the addressed register |
| evt_valid | input | 1 | Event request: load fields and raise interrupt |
| evt_status | input | 7 | Status bits 6:0 for the event |
| evt_reason | input | 8 | Interrupt-reason value for the event |
| evt_step | input | 3 | Sequence-step value for the event |
| flags_valid | input | 1 | Load request for the FIFO-flags register |
| flags_val | input | 8 | FIFO-flags value |
| irq | output | 1 | Interrupt line, active high |

## Verification
The assertions assume that the host raises at most one strobe per cycle and that a strobe lasts exactly one cycle per access. They also assume that a software reset pulse is never combined with an event in a way that needs the event to survive, because reset takes precedence. The bench drives every access through single-cycle tasks that assert one strobe at a time. It overlaps an event with a destructive read only in the dedicated collision step, and it issues the software reset alone.

// File: rtl/isr_pkg.sv
// Shared address map and widths for the interrupt status register unit.
// Assumes a 4-bit, byte-wide host register space.
package isr_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int STEP_W = 3;

    localparam logic [ADDR_W-1:0] A_TC_LO  = 4'h0;
    localparam logic [ADDR_W-1:0] A_TC_MID = 4'h1;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'h4;
    localparam logic [ADDR_W-1:0] A_REASON = 4'h5;
    localparam logic [ADDR_W-1:0] A_STEP   = 4'h6;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'h7;
    localparam logic [ADDR_W-1:0] A_CFG1   = 4'h8;
    localparam logic [ADDR_W-1:0] A_UPPER  = 4'hB;

    localparam int BIT_PEND = 7;
    localparam int BIT_TC   = 4;
endpackage

// File: rtl/isr_status_regs.sv
// Status, reason, step and flags registers plus the interrupt flop.
// Priority per cycle: reset/soft reset, then event, then host side effects.
// Assumes rd_reason and wr_tc are single-cycle decoded strobes.
module isr_status_regs
    import isr_pkg::*;
#(
    parameter int                 SW      = STEP_W,
    parameter logic [STEP_W-1:0]  STEP_CL = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              rd_reason,
    input  logic              wr_tc,
    input  logic              evt_valid,
    input  logic [DATA_W-2:0] evt_status,
    input  logic [DATA_W-1:0] evt_reason,
    input  logic [SW-1:0]     evt_step,
    input  logic              flags_valid,
    input  logic [DATA_W-1:0] flags_val,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] reason_q,
    output logic [SW-1:0]     step_q,
    output logic [DATA_W-1:0] flags_q,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CLR_MASK = ~((DATA_W'(1) << BIT_PEND) | (DATA_W'(1) << BIT_TC));

    // Register updates: event wins over clear-on-read and count-write clears.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            stat_q   <= '0;
            reason_q <= '0;
            step_q   <= '0;
            flags_q  <= '0;
        end else begin
            if (evt_valid) begin
                stat_q   <= {1'b1, evt_status};
                reason_q <= evt_reason;
                step_q   <= evt_step;
            end else if (rd_reason) begin
                stat_q   <= stat_q & CLR_MASK;
                reason_q <= '0;
                step_q   <= STEP_CL;
            end else if (wr_tc) begin
                stat_q[BIT_TC] <= 1'b0;
            end
            if (flags_valid) flags_q <= flags_val;
        end
    end

    // Interrupt line: raised only when not already pending, lowered by reason read.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)          irq <= 1'b0;
        else if (evt_valid && !irq)    irq <= 1'b1;
        else if (rd_reason && !evt_valid) irq <= 1'b0;
    end

    // R2
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !sw_rst) |=> irq);
    // R2
    irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !sw_rst) |=> (irq == stat_q[BIT_PEND]));
    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reason && !evt_valid && !sw_rst) |=> (!irq && step_q == STEP_CL && reason_q == '0));
    // R7
    sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (!irq && stat_q == '0));
    // R8
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tc && !evt_valid && !sw_rst) |=> (!stat_q[BIT_TC] && $stable(irq)));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && rd_reason && !sw_rst) |=> (irq && reason_q == $past(evt_reason)));
endmodule

// File: rtl/isr_config_regs.sv
// Configuration byte and a bank of upper read/write registers.
// One entry of the bank carries a fixed reset code (chip identification).
// Assumes wr is a single-cycle host write strobe.
module isr_config_regs
    import isr_pkg::*;
#(
    parameter int                 N_UP     = 5,
    parameter logic [ADDR_W-1:0]  UP_BASE  = A_UPPER,
    parameter int                 ID_IDX   = 3,
    parameter logic [DATA_W-1:0]  ID_CODE  = 8'h04,
    parameter logic [DATA_W-1:0]  CFG1_RST = 8'h07
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sw_rst,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           cfg1_q,
    output logic [N_UP-1:0][DATA_W-1:0] up_q
);
    // Configuration byte: host-writable, reset to its default.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)         cfg1_q <= CFG1_RST;
        else if (wr && addr == A_CFG1) cfg1_q <= wdata;
    end

    // Upper bank: one flop byte per address, identification entry resets to its code.
    for (genvar i = 0; i < N_UP; i++) begin : g_up
        localparam logic [DATA_W-1:0] RV = (i == ID_IDX) ? ID_CODE : '0;
        localparam logic [ADDR_W-1:0] MY = UP_BASE + ADDR_W'(i);
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst)   up_q[i] <= RV;
            else if (wr && addr == MY) up_q[i] <= wdata;
        end
    end

    // R6
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CFG1 && !sw_rst) |=> (cfg1_q == $past(wdata)));
endmodule

// File: rtl/isr_read_mux.sv
// Combinational readback selection by host address.
// Addresses not owned by this unit read as zero.
module isr_read_mux
    import isr_pkg::*;
#(
    parameter int N_UP = 5
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           stat_q,
    input  logic [DATA_W-1:0]           reason_q,
    input  logic [STEP_W-1:0]           step_q,
    input  logic [DATA_W-1:0]           flags_q,
    input  logic [DATA_W-1:0]           cfg1_q,
    input  logic [N_UP-1:0][DATA_W-1:0] up_q,
    output logic [DATA_W-1:0]           rdata
);
    localparam int UP_LO = int'(A_UPPER);
    localparam int UP_HI = UP_LO + N_UP - 1;

    // Address decode for the readback bus.
    always_comb begin
        rdata = '0;
        if (int'(addr) >= UP_LO && int'(addr) <= UP_HI) begin
            rdata = up_q[int'(addr) - UP_LO];
        end else begin
            case (addr)
                A_STAT:   rdata = stat_q;
                A_REASON: rdata = reason_q;
                A_STEP:   rdata = DATA_W'(step_q);
                A_FLAGS:  rdata = flags_q;
                A_CFG1:   rdata = cfg1_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/isr_unit.sv
// Top of the interrupt status register unit: decodes host strobes into
// side-effect pulses and wires the register groups to the readback mux.
// Assumes at most one host strobe per cycle.
module isr_unit
    import isr_pkg::*;
#(
    parameter int N_UP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [3:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              evt_valid,
    input  logic [6:0]        evt_status,
    input  logic [7:0]        evt_reason,
    input  logic [2:0]        evt_step,
    input  logic              flags_valid,
    input  logic [7:0]        flags_val,
    output logic              irq
);
    logic                        rd_reason, wr_tc;
    logic [DATA_W-1:0]           stat_q, reason_q, flags_q, cfg1_q;
    logic [STEP_W-1:0]           step_q;
    logic [N_UP-1:0][DATA_W-1:0] up_q;

    // Side-effect strobes from host accesses.
    always_comb begin
        rd_reason = host_rd && host_addr == A_REASON;
        wr_tc     = host_wr && (host_addr == A_TC_LO || host_addr == A_TC_MID);
    end

    isr_status_regs u_stat (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .rd_reason(rd_reason), .wr_tc(wr_tc),
        .evt_valid(evt_valid), .evt_status(evt_status),
        .evt_reason(evt_reason), .evt_step(evt_step),
        .flags_valid(flags_valid), .flags_val(flags_val),
        .stat_q(stat_q), .reason_q(reason_q), .step_q(step_q),
        .flags_q(flags_q), .irq(irq)
    );

    isr_config_regs #(.N_UP(N_UP)) u_cfg (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
        .cfg1_q(cfg1_q), .up_q(up_q)
    );

    isr_read_mux #(.N_UP(N_UP)) u_mux (
        .addr(host_addr), .stat_q(stat_q), .reason_q(reason_q),
        .step_q(step_q), .flags_q(flags_q), .cfg1_q(cfg1_q),
        .up_q(up_q), .rdata(host_rdata)
    );

    // R9
    other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr != A_REASON && !evt_valid && !sw_rst) |=> $stable(irq));
endmodule

// File: tb/sim_isr_unit.sv
module sim_isr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       evt_valid = 1'b0;
    logic [6:0] evt_status = '0;
    logic [7:0] evt_reason = '0;
    logic [2:0] evt_step = '0;
    logic       flags_valid = 1'b0;
    logic [7:0] flags_val = '0;
    logic       irq;

    int checks = 0, fails = 0;
    logic [7:0] exp [16];
    logic       exp_irq;

    always #2 clk = ~clk;

    isr_unit u0 (.*);

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, want);
        end
    endtask

    task automatic reset_model();
        for (int i = 0; i < 16; i++) exp[i] = 8'h00;
        exp[8]  = 8'h07;
        exp[14] = 8'h04;
        exp_irq = 1'b0;
    endtask

    // one-cycle host write; model updated from R5/R6/R8
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        if (a == 4'h8 || a >= 4'hB) exp[a] = d;
        if (a <= 4'h1) exp[4][4] = 1'b0;
    endtask

    // one-cycle host read checked against model; side effects per R3
    task automatic rd(input logic [3:0] a, input string req);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 chk(req, host_rdata, exp[a]);
        @(negedge clk);
        host_rd = 1'b0;
        if (a == 4'h5) begin
            exp[5] = 8'h00; exp[4] = exp[4] & 8'h6F; exp[6] = 8'h04; exp_irq = 1'b0;
        end
    endtask

    task automatic post(input logic [6:0] s, input logic [7:0] r, input logic [2:0] st);
        @(negedge clk);
        evt_valid = 1'b1; evt_status = s; evt_reason = r; evt_step = st;
        @(negedge clk);
        evt_valid = 1'b0;
        exp[4] = {1'b1, s}; exp[5] = r; exp[6] = {5'b0, st}; exp_irq = 1'b1;
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 16; a++) if (a != 5) rd(4'(a), req);
        chk({req, " irq"}, {7'b0, irq}, {7'b0, exp_irq});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        reset_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values everywhere
        read_all("R1");
        rd(4'h5, "R1");
        // R5 R6 write sweep over the whole space
        for (int a = 0; a < 16; a++) if (a != 2 && a != 3) wr(4'(a), 8'hA0 + 8'(a));
        read_all("R5/R6");
        // R2 R4 R3 per phase code
        for (int p = 0; p < 8; p++) begin
            if (p == 4 || p == 5) continue;
            post({4'b0101, 3'(p)}, 8'h18 + 8'(p), 3'd2);
            chk("R2 irq", {7'b0, irq}, 8'h01);
            rd(4'h4, "R4");
            rd(4'h5, "R3");
            chk("R3 irq", {7'b0, irq}, 8'h00);
            rd(4'h4, "R3");
            rd(4'h6, "R3");
        end
        // R2 second event while pending keeps irq high
        post(7'h11, 8'h08, 3'd1);
        post(7'h13, 8'h10, 3'd3);
        chk("R2 hold", {7'b0, irq}, 8'h01);
        // R9 reads of other addresses change nothing
        read_all("R9");
        // R8 count writes clear terminal count only
        wr(4'h0, 8'h55);
        rd(4'h4, "R8");
        chk("R8 irq", {7'b0, irq}, 8'h01);
        post(7'h17, 8'h10, 3'd3);
        wr(4'h1, 8'h66);
        rd(4'h4, "R8");
        // R10 event and destructive read collide
        @(negedge clk);
        evt_valid = 1'b1; evt_status = 7'h45; evt_reason = 8'h20; evt_step = 3'd3;
        host_rd = 1'b1; host_addr = 4'h5;
        #1 chk("R10 old", host_rdata, 8'h10);
        @(negedge clk);
        evt_valid = 1'b0; host_rd = 1'b0;
        exp[4] = 8'hC5; exp[5] = 8'h20; exp[6] = 8'h03; exp_irq = 1'b1;
        chk("R10 irq", {7'b0, irq}, 8'h01);
        rd(4'h4, "R10");
        rd(4'h6, "R10");
        rd(4'h5, "R10");
        // R11 flags load
        @(negedge clk);
        flags_valid = 1'b1; flags_val = 8'h0B;
        @(negedge clk);
        flags_valid = 1'b0; exp[7] = 8'h0B;
        rd(4'h7, "R11");
        // R7 soft reset with interrupt pending
        post(7'h02, 8'h18, 3'd4);
        @(negedge clk);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        reset_model();
        chk("R7 irq", {7'b0, irq}, 8'h00);
        read_all("R7");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule